// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Systematic Encoder

This block turns one serial information sequence into a systematic codeword for a rate-7/8 quasi-cyclic LDPC subcode. With the default parameters it takes 14 blocks of 511 information bits, which is 7154 bits, and adds 1022 parity bits, for a codeword of 8176 bits. Information bits enter one per handshake and go to the output unchanged. At the same time they are folded into two parity accumulators of one circulant width each. After the last information bit, the block streams out the first parity segment and then the second one.

Each parity segment has its own lane. A lane holds a generator row register and a parity accumulator. For each information bit equal to 1, the lane XORs its row register into its accumulator. The row register then rotates by one column. At every circulant boundary the lane reloads the first row of the next circulant, so no dense generator matrix is stored.

The circulant first rows are computed at elaboration from a fixed formula that stands in for the real code table. A controller with three states sequences the work:
- `ST_IDLE`: waits for the start pulse.
- `ST_LOAD`: absorbs information bits.
- `ST_DRAIN`: streams the parity.

The transitions are:
- START: any state goes to `ST_LOAD` on the start pulse.
- LAST_INFO: `ST_LOAD` goes to `ST_DRAIN` when the last information bit is accepted.
- LAST_PARITY: `ST_DRAIN` goes to `ST_IDLE` when the last parity bit is accepted.

Top module: `qcldpc_enc`

## Requirements
- R1: After reset the block is in `ST_IDLE`, with `in_ready` and `out_valid` both low.
- R2: A one-cycle `start` pulse, in any state, clears both accumulators and all counters, loads each lane with the first row of block 0, and enters `ST_LOAD`. A pulse in the middle of a sequence abandons that sequence.
- R3: In `ST_LOAD`, `in_ready` equals `out_ready` (and is low while `start` is high). Each accepted information bit appears on `out_bit` in the same cycle, unchanged and in arrival order.
- R4: In `ST_LOAD`, `out_valid` is low whenever `in_valid` is low. Idle gaps on the input do not change the parity.
- R5: Information bit i has block index b = i / CIRC and offset r = i mod CIRC. Parity bit j (0-based) of segment c equals the XOR, over all information bits equal to 1, of bit ((j - r) mod CIRC) of the first row of circulant (b, c). This is the first row rotated r columns toward higher column index.
- R6: Bit k of the first row of circulant (b, c) is 1 exactly when (k*(2b+c+1) + 3b + c) mod 5 equals 0, with b and c 0-based.
- R7: After NBLK*CIRC accepted information bits, the block emits the CIRC bits of segment 0 in order j = 0..CIRC-1, then the CIRC bits of segment 1 in the same order.
- R8: While a parity bit is offered and `out_ready` is low, `out_valid` stays high and `out_bit` holds its value.
- R9: After the last parity bit is accepted, the block returns to `ST_IDLE`. There it keeps `out_valid` and `in_ready` low and ignores `in_valid` until the next `start`.
- R10: An all-zero information sequence produces all-zero parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new sequence; clears the accumulators and counters |
| in_valid | input | 1 | Information bit is present |
| in_ready | output | 1 | Information bit is accepted this cycle when `in_valid` is high |
| in_bit | input | 1 | Serial information bit |
| out_valid | output | 1 | Codeword bit is present |
| out_ready | input | 1 | Downstream accepts the codeword bit |
| out_bit | output | 1 | Serial codeword bit: the information bits, then the parity bits |

## Verification
The main function is exercised with five input patterns, each aimed at a different fault:
- All-zero information: separates a correct accumulator from one that leaks generator rows in without a 1 bit.
- A single 1 at bit 0: exposes the first row of each circulant directly, so the row formula and the reload order can be seen on the outputs.
- A pair of 1s straddling the first circulant boundary: shows whether the reload happens at exactly the right bit and whether the rotation direction is correct.
- Pseudo-random and all-ones sequences, driven with input gaps and a toggling `out_ready`: mix many rotated rows and show that stalls at either side neither drop nor duplicate a step.

A final run abandons a sequence part way with a fresh `start`, which shows that the clear really discards the partial parity.

// File: rtl/qcldpc_pkg.sv
package qcldpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_DRAIN = 2'd2
    } enc_state_e;

    // First-row pattern of circulant (blk, col): column k holds a 1 when
    // (k*(2*blk+col+1) + 3*blk + col) mod 5 == 0.
    function automatic logic row_bit(input int blk, input int col, input int k);
        return ((k * (2 * blk + col + 1) + 3 * blk + col) % 5) == 0;
    endfunction

endpackage

// File: rtl/qcldpc_lane.sv
module qcldpc_lane #(
    parameter int CIRC = 511
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            step,
    input  logic            info_bit,
    input  logic            reload,
    input  logic            shift,
    input  logic [CIRC-1:0] row_in,
    output logic            acc_lsb
);

    logic [CIRC-1:0] gen_q;
    logic [CIRC-1:0] acc_q;
    logic [CIRC-1:0] gen_rot;

    // Rotation moves column k to column k+1, wrapping the top column to 0.
    assign gen_rot = {gen_q[CIRC-2:0], gen_q[CIRC-1]};
    assign acc_lsb = acc_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q <= '0;
            acc_q <= '0;
        end else if (clear) begin
            gen_q <= row_in;
            acc_q <= '0;
        end else if (step) begin
            if (info_bit) begin
                acc_q <= acc_q ^ gen_q;
            end
            gen_q <= reload ? row_in : gen_rot;
        end else if (shift) begin
            acc_q <= {1'b0, acc_q[CIRC-1:1]};
        end
    end

    // R2: a start clears the parity accumulator
    assert_clear_acc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == '0));

    // R10: a zero bit leaves the accumulator untouched
    assert_zero_bit_keeps_acc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && !info_bit) |=> $stable(acc_q));

endmodule

// File: rtl/qcldpc_ctrl.sv
module qcldpc_ctrl
    import qcldpc_pkg::*;
#(
    parameter int CIRC = 511,
    parameter int NBLK = 14,
    localparam int RW = $clog2(CIRC),
    localparam int BW = $clog2(NBLK + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          in_valid,
    input  logic          out_ready,
    output enc_state_e    state,
    output logic          in_ready,
    output logic          out_valid,
    output logic          step,
    output logic          reload,
    output logic          shift,
    output logic          seg,
    output logic [BW-1:0] row_idx
);

    localparam logic [RW-1:0] CNT_LAST = RW'(CIRC - 1);
    localparam logic [BW-1:0] BLK_LAST = BW'(NBLK - 1);

    enc_state_e    state_q, state_d;
    logic [RW-1:0] cnt_q;
    logic [BW-1:0] blk_q;
    logic          seg_q;
    logic          cnt_last;
    logic          blk_last;

    assign state    = state_q;
    assign seg      = seg_q;
    assign cnt_last = (cnt_q == CNT_LAST);
    assign blk_last = (blk_q == BLK_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: START, LAST_INFO, LAST_PARITY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_LOAD;
            end
            ST_LOAD: begin
                if (start)                              state_d = ST_LOAD;
                else if (step && cnt_last && blk_last)  state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (start)                              state_d = ST_LOAD;
                else if (shift && cnt_last && seg_q)    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        step      = 1'b0;
        shift     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_LOAD: begin
                in_ready  = !start && out_ready;
                out_valid = !start && in_valid;
                step      = !start && in_valid && out_ready;
            end
            ST_DRAIN: begin
                out_valid = !start;
                shift     = !start && out_ready;
            end
            default: begin
            end
        endcase
        reload  = step && cnt_last;
        row_idx = start ? '0 : (blk_last ? blk_q : blk_q + 1'b1);
    end

    // Bit, block and segment counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            blk_q <= '0;
            seg_q <= 1'b0;
        end else if (start) begin
            cnt_q <= '0;
            blk_q <= '0;
            seg_q <= 1'b0;
        end else if (step) begin
            if (cnt_last) begin
                cnt_q <= '0;
                blk_q <= blk_last ? '0 : blk_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (shift) begin
            if (cnt_last) begin
                cnt_q <= '0;
                seg_q <= ~seg_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3: the input is only accepted in the information phase
    assert_ready_only_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (state_q == ST_LOAD));

    // R4: no output without upstream data during the information phase
    assert_valid_follows_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && !in_valid) |-> !out_valid);

    // R7: the bit counter stays inside one circulant
    assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);

    // R8: a stalled parity offer keeps its position
    assert_drain_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && out_valid && !out_ready && !start) |=>
        (state_q == ST_DRAIN && $stable(cnt_q) && $stable(seg_q)));

    // R9: idle is silent on both sides
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!out_valid && !in_ready));

endmodule

// File: rtl/qcldpc_enc.sv
module qcldpc_enc
    import qcldpc_pkg::*;
#(
    parameter int CIRC = 511,
    parameter int NBLK = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_bit,
    output logic out_valid,
    input  logic out_ready,
    output logic out_bit
);

    localparam int NSEG = 2;
    localparam int BW   = $clog2(NBLK + 1);
    localparam int TABW = NSEG * NBLK * CIRC;

    function automatic logic [TABW-1:0] build_tab();
        logic [TABW-1:0] t;
        t = '0;
        for (int b = 0; b < NBLK; b++) begin
            for (int c = 0; c < NSEG; c++) begin
                for (int k = 0; k < CIRC; k++) begin
                    t[(b * NSEG + c) * CIRC + k] = row_bit(b, c, k);
                end
            end
        end
        return t;
    endfunction

    localparam logic [TABW-1:0] ROW_TAB = build_tab();

    enc_state_e      state;
    logic            step;
    logic            reload;
    logic            shift;
    logic            seg;
    logic [BW-1:0]   row_idx;
    logic [NSEG-1:0] lane_lsb;

    qcldpc_ctrl #(
        .CIRC (CIRC),
        .NBLK (NBLK)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .state     (state),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .step      (step),
        .reload    (reload),
        .shift     (shift),
        .seg       (seg),
        .row_idx   (row_idx)
    );

    for (genvar g = 0; g < NSEG; g++) begin : g_lane
        logic [CIRC-1:0] row_sel;
        assign row_sel = ROW_TAB[(32'(row_idx) * NSEG + g) * CIRC +: CIRC];

        qcldpc_lane #(
            .CIRC (CIRC)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (start),
            .step     (step),
            .info_bit (in_bit),
            .reload   (reload),
            .shift    (shift && (seg == 1'(g))),
            .row_in   (row_sel),
            .acc_lsb  (lane_lsb[g])
        );
    end

    assign out_bit = (state == ST_DRAIN) ? lane_lsb[seg] : in_bit;

    // R8: a held parity bit does not change while stalled
    assert_parity_bit_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && out_valid && !out_ready && !start) |=> $stable(out_bit));

    // R3: the information bit passes straight through
    assert_passthrough_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && out_valid) |-> (out_bit == in_bit));

endmodule

// File: tb/qcldpc_enc_test.sv
`timescale 1ns/1ps
module qcldpc_enc_test;

    localparam int CIRC  = 15;
    localparam int NBLK  = 3;
    localparam int NINFO = CIRC * NBLK;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic out_ready = 1'b1;
    logic in_ready;
    logic out_valid;
    logic out_bit;

    int checks = 0;
    int errors = 0;

    logic  exp_q[$];
    string tag_q[$];

    logic       in_info = 1'b0;
    logic       ready_rand = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    always #2 clk = ~clk;

    qcldpc_enc #(.CIRC(CIRC), .NBLK(NBLK)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_bit    (in_bit),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_bit   (out_bit)
    );

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    function automatic logic tb_row(input int b, input int c, input int k);
        return ((k * (2 * b + c + 1) + 3 * b + c) % 5) == 0;
    endfunction

    // out_ready pattern: steady high, or pseudo-random
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = ready_rand ? (lfsr[0] | lfsr[2]) : 1'b1;
    end

    // Monitor: pops the scoreboard at each output handshake
    logic held_v = 1'b0;
    logic held_b = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (held_v) begin
                chk(out_valid, 1'b1, "R8", "valid held during stall");
                chk(out_bit, held_b, "R8", "parity bit held during stall");
            end
            held_v = 1'b0;
            if (in_info && !in_valid) begin
                chk(out_valid, 1'b0, "R4", "out_valid during input gap");
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R9 unexpected output: actual %b expected none", out_bit);
                end else begin
                    chk(out_bit, exp_q.pop_front(), tag_q.pop_front(), "codeword bit");
                end
            end else if (out_valid && !out_ready && exp_q.size() > 0 && tag_q[0] != "R3") begin
                held_v = 1'b1;
                held_b = out_bit;
            end
        end
    end

    // Driver: runs one sequence; stops early when abort_at >= 0
    task automatic run_seq(input logic [NINFO-1:0] info, input bit gaps,
                           input string ptag, input int abort_at);
        logic fired;
        @(posedge clk); #1;
        start = 1'b1;
        in_valid = 1'b0;
        @(posedge clk); #1;
        start = 1'b0;
        in_info = 1'b1;
        for (int i = 0; i < NINFO; i++) begin
            if (i == abort_at) begin
                in_valid = 1'b0;
                in_info = 1'b0;
                return;
            end
            if (gaps && (i % 3 == 1)) begin
                in_valid = 1'b0;
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_bit = info[i];
            exp_q.push_back(info[i]);
            tag_q.push_back("R3");
            fired = 1'b0;
            while (!fired) begin
                @(negedge clk);
                fired = in_valid && in_ready;
                @(posedge clk); #1;
            end
        end
        in_valid = 1'b0;
        in_info = 1'b0;
        // Expected parity, from the R5/R6 definition; order per R7
        for (int c = 0; c < 2; c++) begin
            for (int j = 0; j < CIRC; j++) begin
                logic p;
                p = 1'b0;
                for (int i = 0; i < NINFO; i++) begin
                    if (info[i]) p ^= tb_row(i / CIRC, c, (j - (i % CIRC) + CIRC) % CIRC);
                end
                exp_q.push_back(p);
                tag_q.push_back(ptag);
            end
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic idle_check();
        in_valid = 1'b1;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            chk(out_valid, 1'b0, "R9", "out_valid in idle");
            chk(in_ready, 1'b0, "R9", "in_ready in idle");
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    initial begin
        logic [NINFO-1:0] pat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready, 1'b0, "R1", "in_ready after reset");
        chk(out_valid, 1'b0, "R1", "out_valid after reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready, 1'b0, "R1", "in_ready idle after reset release");

        run_seq('0, 1'b0, "R10", -1);
        idle_check();

        pat = '0;
        pat[0] = 1'b1;
        run_seq(pat, 1'b0, "R5 R6 R7", -1);

        pat = '0;
        pat[CIRC-1] = 1'b1;
        pat[CIRC] = 1'b1;
        run_seq(pat, 1'b0, "R5 R6 R7 boundary", -1);

        ready_rand = 1'b1;
        for (int i = 0; i < NINFO; i++) pat[i] = ((i * 7 + i / 4) % 3) == 0;
        run_seq(pat, 1'b1, "R4 R5 R8", -1);

        run_seq('1, 1'b1, "R5 R8 all ones", -1);
        idle_check();

        ready_rand = 1'b0;
        run_seq('1, 1'b0, "R2", 10);
        while (exp_q.size() != 0) @(negedge clk);
        for (int i = 0; i < NINFO; i++) pat[i] = (i % 4) == 1;
        run_seq(pat, 1'b0, "R2 after abort", -1);
        idle_check();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule